// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic device. Twelve dedicated inputs and ten feedback signals are each offered to the array in true and inverted form. That gives 44 columns. The array builds 132 product terms. Each term is the AND of whichever literals its fuse word keeps connected. Fixed OR gates then combine the terms into ten output sums of unequal width. Each output also has its own enable term. One shared term requests a reset and one shared term requests a preset. The macrocells that consume these signals sit outside this block.

The fuse pattern is loaded serially, one bit per clock, while a load strobe is high. When the last bit has been written, a done flag rises and the array outputs start to follow the inputs combinationally. A readback port returns any term's fuse word. A security flag, once set, hides the pattern: every bit then reads as an opened fuse. Only an erase or a reset clears the security flag. An erase also returns every fuse to its connected state and re-arms loading.

Top module: `spa_array`

## Requirements
- R1: After reset or an erase, every fuse reads back as 1 (connected), `cfg_done` is 0, the security flag is clear, and all array outputs are 0.
- R2: Each clock edge with `cfg_load` high and `cfg_done` low writes `cfg_bit` into the next fuse. The order is term 0 columns 0 to 43, then term 1, and so on up to term 131. `cfg_done` rises on the edge that writes the 5808th bit.
- R3: Once `cfg_done` is high, `cfg_load` has no effect: readback and outputs stay unchanged.
- R4: Array input k is `ded_in[k]` for k < 12 and `fb_in[k-12]` otherwise. Column 2k is its true form and column 2k+1 its inverted form. A fuse value of 1 connects the column to the term. A term is the AND of its connected literals, so a term with every fuse at 0 is 1.
- R5: A term with both columns of any one input connected is 0 for every input value.
- R6: Term 0 is the reset term and term 131 is the preset term. Between them, for outputs 0 to 9 in order, come one enable term and then that output's sum terms. The sum widths are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8.
- R7: `sum_out[j]` is the OR of output j's sum terms, `oe_out[j]` is its enable term, and `rst_term` and `pre_term` are terms 0 and 131.
- R8: While `cfg_done` is 0, `sum_out`, `oe_out`, `rst_term` and `pre_term` are all 0.
- R9: `rd_word` is the fuse word of term `rd_term`. It is 0 when `rd_term` is 132 or more.
- R10: `cfg_secure` sets the security flag. While the flag is set, `rd_word` is 0 for every term and the array keeps working. The flag stays set until an erase or a reset.
- R11: `cfg_erase` takes priority over `cfg_load` and `cfg_secure` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, equivalent to an erase |
| cfg_erase | input | 1 | Erase the whole array and clear the flags |
| cfg_secure | input | 1 | Set the security flag |
| cfg_load | input | 1 | Load strobe for one configuration bit |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | All fuses loaded; array active |
| rd_term | input | 8 | Term index for readback |
| rd_word | output | 44 | Fuse word of the selected term |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback array inputs |
| sum_out | output | 10 | Per-output OR sums |
| oe_out | output | 10 | Per-output enable terms |
| rst_term | output | 1 | Shared reset term |
| pre_term | output | 1 | Shared preset term |

## Verification
A fuse bit written to the wrong place shows up on `rd_word` as soon as that term is selected, in the cycle after the write. It also corrupts every later bit, because the write pointer has slipped. A done flag that rises early or late is visible on `cfg_done` at the exact edge, and it enables or silences the outputs at the same time. A wrong literal or term-to-output mapping only shows on `sum_out` or `oe_out` once an input vector makes that term decisive. For that reason the bench compares every output against a behavioural model on every clock, over many random input vectors.

// File: rtl/spa_pkg.sv
package spa_pkg;
    localparam int DED_W = 12;
    localparam int FB_W  = 10;
    localparam int N_OUT = FB_W;
    localparam int IN_W  = DED_W + FB_W;
    localparam int COLS  = 2 * IN_W;
    localparam int SUM_CNT [N_OUT] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    // Reset term, preset term, one enable term per output, plus the sums.
    function automatic int calc_terms();
        int t;
        t = 2 + N_OUT;
        for (int i = 0; i < N_OUT; i++) t += SUM_CNT[i];
        return t;
    endfunction

    // Index of output j's enable term; its sum terms follow directly.
    function automatic int oe_idx(int j);
        int idx;
        idx = 1;
        for (int i = 0; i < j; i++) idx += 1 + SUM_CNT[i];
        return idx;
    endfunction

    localparam int TERMS = calc_terms();
    localparam int TW    = $clog2(TERMS);
    localparam int CW    = $clog2(COLS);
endpackage

// File: rtl/spa_cfg.sv
module spa_cfg
    import spa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        erase,
    input  logic                        sec_set,
    input  logic                        load_en,
    input  logic                        load_bit,
    output logic [TERMS-1:0][COLS-1:0]  fuse_o,
    output logic                        done_o,
    output logic                        sec_o
);
    localparam logic [TW-1:0] LAST_T = TW'(TERMS - 1);
    localparam logic [CW-1:0] LAST_C = CW'(COLS - 1);

    typedef struct packed {
        logic [TERMS-1:0][COLS-1:0] fuse;
        logic [TW-1:0]              term;
        logic [CW-1:0]              col;
        logic                       done;
        logic                       sec;
    } cfg_t;

    localparam cfg_t CFG_INIT = '{fuse: '1, term: '0, col: '0, done: 1'b0, sec: 1'b0};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (erase) begin
            cfg_d = CFG_INIT;
        end else begin
            if (sec_set) cfg_d.sec = 1'b1;
            if (load_en && !cfg_q.done) begin
                cfg_d.fuse[cfg_q.term][cfg_q.col] = load_bit;
                if (cfg_q.col == LAST_C) begin
                    cfg_d.col = '0;
                    if (cfg_q.term == LAST_T) cfg_d.done = 1'b1;
                    else                      cfg_d.term = cfg_q.term + 1'b1;
                end else begin
                    cfg_d.col = cfg_q.col + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_INIT;
        else        cfg_q <= cfg_d;
    end

    assign fuse_o = cfg_q.fuse;
    assign done_o = cfg_q.done;
    assign sec_o  = cfg_q.sec;

    // R3: a finished load stays finished and frozen until erased.
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.done && !erase) |=> cfg_q.done);
    p_fuse_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.done && !erase) |=> $stable(cfg_q.fuse));
    // R10: security cannot be dropped without an erase.
    p_sec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sec && !erase) |=> cfg_q.sec);
    // R11: erase wins over load and secure.
    p_erase_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (!cfg_q.done && !cfg_q.sec && cfg_q.term == '0 && cfg_q.col == '0));
endmodule

// File: rtl/spa_term.sv
module spa_term
    import spa_pkg::*;
(
    input  logic [COLS-1:0] fuse,
    input  logic [IN_W-1:0] x,
    output logic            hit
);
    logic [IN_W-1:0] lit_ok;

    for (genvar k = 0; k < IN_W; k++) begin : g_lit
        assign lit_ok[k] = ~(fuse[2*k] & ~x[k]) & ~(fuse[2*k+1] & x[k]);
    end

    assign hit = &lit_ok;
endmodule

// File: rtl/spa_or.sv
module spa_or #(
    parameter int CNT = 8
) (
    input  logic [CNT:0] grp,
    output logic         sum_o,
    output logic         oe_o
);
    assign oe_o  = grp[0];
    assign sum_o = |grp[CNT:1];
endmodule

// File: rtl/spa_array.sv
module spa_array
    import spa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_erase,
    input  logic              cfg_secure,
    input  logic              cfg_load,
    input  logic              cfg_bit,
    output logic              cfg_done,
    input  logic [TW-1:0]     rd_term,
    output logic [COLS-1:0]   rd_word,
    input  logic [DED_W-1:0]  ded_in,
    input  logic [FB_W-1:0]   fb_in,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_out,
    output logic              rst_term,
    output logic              pre_term
);
    logic [TERMS-1:0][COLS-1:0] fuse_w;
    logic                       done_w;
    logic                       sec_w;
    logic [IN_W-1:0]            lit_in;
    logic [TERMS-1:0]           term_hit;
    logic [N_OUT-1:0]           sum_raw;
    logic [N_OUT-1:0]           oe_raw;

    spa_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase    (cfg_erase),
        .sec_set  (cfg_secure),
        .load_en  (cfg_load),
        .load_bit (cfg_bit),
        .fuse_o   (fuse_w),
        .done_o   (done_w),
        .sec_o    (sec_w)
    );

    assign lit_in = {fb_in, ded_in};

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        spa_term u_term (
            .fuse (fuse_w[t]),
            .x    (lit_in),
            .hit  (term_hit[t])
        );
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        localparam int BASE = oe_idx(j);
        spa_or #(.CNT(SUM_CNT[j])) u_or (
            .grp   (term_hit[BASE +: SUM_CNT[j] + 1]),
            .sum_o (sum_raw[j]),
            .oe_o  (oe_raw[j])
        );
    end

    assign cfg_done = done_w;
    assign sum_out  = done_w ? sum_raw : '0;
    assign oe_out   = done_w ? oe_raw  : '0;
    assign rst_term = done_w & term_hit[0];
    assign pre_term = done_w & term_hit[TERMS-1];

    always_comb begin
        rd_word = '0;
        if (!sec_w && rd_term < TW'(TERMS)) rd_word = fuse_w[rd_term];
    end
endmodule

// File: tb/spa_array_tb.sv
module spa_array_tb;
    localparam int NT = 132;
    localparam int NC = 44;
    localparam int NB = NT * NC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_erase = 1'b0, cfg_secure = 1'b0, cfg_load = 1'b0, cfg_bit = 1'b0;
    logic        cfg_done;
    logic [7:0]  rd_term = 8'd0;
    logic [43:0] rd_word;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out, oe_out;
    logic        rst_term, pre_term;

    spa_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_erase(cfg_erase), .cfg_secure(cfg_secure),
        .cfg_load(cfg_load), .cfg_bit(cfg_bit), .cfg_done(cfg_done),
        .rd_term(rd_term), .rd_word(rd_word), .ded_in(ded_in), .fb_in(fb_in),
        .sum_out(sum_out), .oe_out(oe_out), .rst_term(rst_term), .pre_term(pre_term)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    // Reference model state
    logic [43:0] m_fuse [NT];
    logic [43:0] want   [NT];
    int          m_ptr;
    bit          m_done, m_sec;
    int          sz [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    task automatic m_erase();
        for (int t = 0; t < NT; t++) m_fuse[t] = '1;
        m_ptr = 0; m_done = 1'b0; m_sec = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!rst_n || cfg_erase) m_erase();
        else begin
            if (cfg_secure) m_sec = 1'b1;
            if (cfg_load && !m_done) begin
                m_fuse[m_ptr / NC][m_ptr % NC] = cfg_bit;
                m_ptr++;
                if (m_ptr == NB) m_done = 1'b1;
            end
        end
    end

    function automatic bit tv(int t);
        bit v = 1'b1;
        logic [21:0] x = {fb_in, ded_in};
        for (int k = 0; k < 22; k++) begin
            if (m_fuse[t][2*k]   && !x[k]) v = 1'b0;
            if (m_fuse[t][2*k+1] &&  x[k]) v = 1'b0;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            logic [9:0] e_sum, e_oe;
            int idx;
            e_sum = '0; e_oe = '0; idx = 1;
            for (int j = 0; j < 10; j++) begin
                e_oe[j] = tv(idx); idx++;
                for (int n = 0; n < sz[j]; n++) begin
                    e_sum[j] |= tv(idx); idx++;
                end
            end
            if (!m_done) begin e_sum = '0; e_oe = '0; end
            check("R2 done flag", 64'(cfg_done), 64'(m_done));
            check(m_sec ? "R10 readback" : "R9 readback", 64'(rd_word),
                  (m_sec || rd_term >= NT) ? 64'd0 : 64'(m_fuse[rd_term]));
            check("R7 sum_out", 64'(sum_out), 64'(e_sum));
            check("R7 oe_out", 64'(oe_out), 64'(e_oe));
            check("R7 rst_term", 64'(rst_term), 64'(m_done && tv(0)));
            check("R7 pre_term", 64'(pre_term), 64'(m_done && tv(NT-1)));
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic load_bits(int n);
        for (int i = 0; i < n; i++) begin
            cfg_bit  = want[i / NC][i % NC];
            cfg_load = 1'b1;
            rd_term  = 8'(i % 141);
            ded_in   = 12'($urandom);
            fb_in    = 10'($urandom);
            if (i == NB - 1) check("R2 done low before last bit", 64'(cfg_done), 64'd0);
            tick();
        end
        cfg_load = 1'b0;
    endtask

    task automatic do_erase();
        cfg_erase = 1'b1; tick(); cfg_erase = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_erase();
        // Pattern 1: sparse random literals; fixed reset and preset terms.
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < 22; k++) begin
                int r = $urandom_range(31);
                want[t][2*k]   = (r >= 26 && r <= 28) || r == 31;
                want[t][2*k+1] = (r >= 29);
            end
        end
        want[0]    = '0;                  // all fuses opened -> always 1 (R4)
        want[NT-1] = 44'h0000_0000_C00;   // both forms of input 5 -> always 0 (R5)

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        // R1 / R8: reset state
        rd_term = 8'd0; #1;
        check("R1 done after reset", 64'(cfg_done), 64'd0);
        check("R1 term0 readback", 64'(rd_word), 64'hFFF_FFFF_FFFF);
        rd_term = 8'd131; ded_in = 12'hA5C; fb_in = 10'h3C3; #1;
        check("R1 term131 readback", 64'(rd_word), 64'hFFF_FFFF_FFFF);
        check("R8 outputs idle", 64'({sum_out, oe_out, rst_term, pre_term}), 64'd0);
        rd_term = 8'd132; #1;
        check("R9 out-of-range 132", 64'(rd_word), 64'd0);
        rd_term = 8'd200; #1;
        check("R9 out-of-range 200", 64'(rd_word), 64'd0);

        // R2: partial load lands in order
        load_bits(100);
        rd_term = 8'd1; #1;
        check("R2 term1 loaded", 64'(rd_word), 64'(want[1]));
        rd_term = 8'd2; #1;
        check("R2 term2 partial", 64'(rd_word), 64'({32'hFFFF_FFFF, want[2][11:0]}));
        check("R8 idle during load", 64'({sum_out, oe_out, rst_term, pre_term}), 64'd0);

        // R11: erase beats load and secure in the same cycle
        cfg_erase = 1'b1; cfg_load = 1'b1; cfg_secure = 1'b1; cfg_bit = 1'b0;
        tick();
        cfg_erase = 1'b0; cfg_load = 1'b0; cfg_secure = 1'b0;
        rd_term = 8'd0; #1;
        check("R11 erase wins readback", 64'(rd_word), 64'hFFF_FFFF_FFFF);
        check("R11 erase wins done", 64'(cfg_done), 64'd0);

        // R2: full load, done rises on last bit
        load_bits(NB);
        check("R2 done after last bit", 64'(cfg_done), 64'd1);

        // R4/R5/R7: random vectors
        for (int v = 0; v < 300; v++) begin
            ded_in = 12'($urandom); fb_in = 10'($urandom);
            rd_term = 8'($urandom_range(140));
            tick();
            check("R4 open term high", 64'(rst_term), 64'd1);
            check("R5 contradictory term low", 64'(pre_term), 64'd0);
        end

        // R3: loading after done ignored
        for (int i = 0; i < 60; i++) begin
            cfg_load = 1'b1; cfg_bit = 1'b1; tick();
        end
        cfg_load = 1'b0;
        rd_term = 8'd0; #1;
        check("R3 term0 unchanged", 64'(rd_word), 64'd0);
        check("R3 rst_term still high", 64'(rst_term), 64'd1);

        // R10: security hides readback, array still works
        cfg_secure = 1'b1; tick(); cfg_secure = 1'b0;
        rd_term = 8'd131; #1;
        check("R10 secured readback", 64'(rd_word), 64'd0);
        check("R10 array still active", 64'(rst_term), 64'd1);
        repeat (20) tick();
        rd_term = 8'd50; #1;
        check("R10 still secured", 64'(rd_word), 64'd0);
        do_erase();
        rd_term = 8'd131; #1;
        check("R1 erase clears security", 64'(rd_word), 64'hFFF_FFFF_FFFF);
        check("R1 erase clears done", 64'(cfg_done), 64'd0);

        // R6: term layout probe
        for (int t = 0; t < NT; t++) want[t] = '1;
        want[65] = '0;   // last sum term of output 4
        want[98] = '0;   // enable term of output 7
        want[131] = '0;  // preset term
        load_bits(NB);
        for (int v = 0; v < 2; v++) begin
            ded_in = v ? 12'hFFF : 12'h000; fb_in = v ? 10'h155 : 10'h2AA; #1;
            check("R6 sum map", 64'(sum_out), 64'h010);
            check("R6 enable map", 64'(oe_out), 64'h080);
            check("R6 preset term", 64'(pre_term), 64'd1);
            check("R6 reset term", 64'(rst_term), 64'd0);
            tick();
        end

        // R1: asynchronous reset returns to erased state
        #3 rst_n = 1'b0; #2;
        rd_term = 8'd65; #1;
        check("R1 reset done", 64'(cfg_done), 64'd0);
        check("R1 reset outputs", 64'({sum_out, oe_out, rst_term, pre_term}), 64'd0);
        check("R1 reset readback", 64'(rd_word), 64'hFFF_FFFF_FFFF);
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (3) tick();
        finish_run();
    end
endmodule